// File: doc/BRIEF.md
# Dual-Buffer MAC Transmit Controller

This block is the transmit side of a small Ethernet MAC. Software sees a word-addressed register window. The lower half holds two packet buffers. Each buffer carries its own byte-count word and its own control word. A single interrupt-enable register is shared by the whole window. Software fills a buffer with frame bytes, writes the byte count, and then writes the control word. The bits written to the control word choose between two actions. One sends the buffer over a byte-wide valid/ready stream, together with its length and a last flag. The other loads the first six bytes of the buffer into the station address register.

Each control word shows a busy indication while its command is in flight. A buffer that is busy ignores further control writes. When a command completes, the busy bits drop. If the completed command asked for an interrupt and the global enable is set, a one-cycle interrupt pulse is raised. A send command given to one buffer while the other buffer is streaming waits. It starts as soon as the first frame ends. The receive path, PHY signalling, CRC generation and collision handling are outside this block.

Top module: `mactx_top`

## Requirements
- R1: While reset is asserted and after it is released, every control word, byte-count word and the interrupt-enable register read 0. `mac_addr_o` is 0, and `irq_o` and `tx_valid_o` are low.
- R2: The word address is the byte offset divided by 4. Buffer 0 occupies byte offsets 0x000-0x7FF and buffer 1 occupies 0x800-0xFFF. Within each buffer, offset 0x7F4 is the byte-count word and offset 0x7FC is the control word. Offset 0x7F8 of buffer 0 is the interrupt-enable register; offset 0xFF8 is plain buffer storage. Every other word in the lower half is buffer storage that reads back what was written. Offsets 0x1000-0x1FFF read 0 and ignore writes.
- R3: A control write with bit 0 (start) = 1 and bit 1 (address) = 0 streams bytes 0 to N-1 of that buffer, where N is its byte count. Byte k is taken from buffer word k/4, bits [8*(k%4)+7 : 8*(k%4)]. `tx_len_o` shows N, and `tx_last_o` is high on byte N-1 only.
- R4: During a send, the control word reads with bit 0 = 1 and bit 1 = 0, and the other written bits are kept. After completion, bits 1:0 read 0 and the other bits are unchanged.
- R5: A control write with bits 1:0 = 11 streams nothing. One cycle later, `mac_addr_o` holds bytes 0..5 of that buffer, with byte 0 in bits 47:40 and byte 5 in bits 7:0. The control word then reads with bits 1:0 = 0.
- R6: A control write with bit 0 = 0 starts nothing. It stores the written value with bits 1:0 forced to 0.
- R7: While a buffer's control word has bit 0 set, writes to that control word are ignored entirely. This includes attempts to change the retained bits or to start an address load.
- R8: When a command completes, `irq_o` pulses high for one cycle, but only if bit 3 of that buffer's control word is set and bit 31 of the interrupt-enable register is set. Completions on both buffers in the same cycle give a single pulse.
- R9: A send on one buffer that is issued while the other buffer is streaming is held busy. Its frame follows the first frame, and the two frames' bytes do not mix.
- R10: A byte count of 0 sends nothing and completes as any other command does. A byte count above 2036 sends 2036 bytes.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, the data byte and the last flag hold steady, and valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, with `bus_req_i` |
| bus_addr_i | input | 11 | Word address (byte offset / 4) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| tx_valid_o | output | 1 | Frame byte available |
| tx_ready_i | input | 1 | Sink accepts the byte |
| tx_data_o | output | 8 | Frame byte |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_len_o | output | 11 | Byte count of the frame being sent |
| mac_addr_o | output | 48 | Station address |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
A frame can end on buffer 0 in the same clock edge that an address load on buffer 1 finishes. Both completions then raise interrupt requests together. The bench sets this up as follows. It holds the sink not-ready on a one-byte frame and issues the address-load command. It then raises ready in the very next cycle, so the final handshake and the load land on the same edge. The case is judged by three results: exactly one interrupt pulse counted, the new station address, and both control words reading idle with their interrupt bits retained.

// File: rtl/mactx_pkg.sv
package mactx_pkg;
  localparam int NUM_BUF    = 2;
  localparam int REG_W      = 32;
  localparam int CTRL_S_BIT = 0;
  localparam int CTRL_P_BIT = 1;
  localparam int CTRL_I_BIT = 3;
  localparam int GIE_BIT    = 31;
  localparam int SEL_W      = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;

  typedef enum logic {
    ST_IDLE,
    ST_SEND
  } strm_state_e;
endpackage

// File: rtl/mactx_buf_ram.sv
module mactx_buf_ram #(
  parameter int WORDS = 512,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [31:0]      wdata_i,
  input  logic [IDX_W-1:0] bus_raddr_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [IDX_W-1:0] strm_raddr_i,
  output logic [31:0]      strm_rdata_o,
  output logic [47:0]      head_o
);
  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign bus_rdata_o  = mem_q[bus_raddr_i];
  assign strm_rdata_o = mem_q[strm_raddr_i];
  // first byte on the wire lands in the top octet
  assign head_o = {mem_q[0][7:0], mem_q[0][15:8], mem_q[0][23:16], mem_q[0][31:24],
                   mem_q[1][7:0], mem_q[1][15:8]};
endmodule

// File: rtl/mactx_cmd.sv
module mactx_cmd
  import mactx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [REG_W-1:0] ctrl_wdata_i,
  input  logic             tx_done_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic             tx_pend_o,
  output logic             addr_load_o,
  output logic             done_o,
  output logic             irq_req_o
);
  logic [REG_W-1:0] keep_q;
  logic             s_q, p_q;

  assign addr_load_o = s_q & p_q;
  assign tx_pend_o   = s_q & ~p_q;
  assign done_o      = addr_load_o | (tx_pend_o & tx_done_i);
  assign irq_req_o   = done_o & keep_q[CTRL_I_BIT];
  assign ctrl_o      = keep_q | {{(REG_W-2){1'b0}}, p_q, s_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_q <= '0;
      s_q    <= 1'b0;
      p_q    <= 1'b0;
    end else if (ctrl_we_i && !s_q) begin
      keep_q <= ctrl_wdata_i & ~REG_W'(3);
      s_q    <= ctrl_wdata_i[CTRL_S_BIT];
      p_q    <= ctrl_wdata_i[CTRL_S_BIT] & ctrl_wdata_i[CTRL_P_BIT];
    end else if (done_o) begin
      s_q <= 1'b0;
      p_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mactx_stream.sv
module mactx_stream
  import mactx_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  localparam int WORDS     = BUF_BYTES / 4,
  localparam int IDX_W     = $clog2(WORDS),
  localparam int CNT_W     = $clog2(BUF_BYTES),
  localparam int MAX_FRAME = (WORDS - 3) * 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_BUF-1:0]            tx_pend_i,
  input  logic [NUM_BUF-1:0][REG_W-1:0] len_i,
  output logic [SEL_W-1:0]              rd_sel_o,
  output logic [IDX_W-1:0]              rd_idx_o,
  input  logic [31:0]                   rd_word_i,
  output logic                          tx_valid_o,
  input  logic                          tx_ready_i,
  output logic [7:0]                    tx_data_o,
  output logic                          tx_last_o,
  output logic [CNT_W-1:0]              tx_len_o,
  output logic [NUM_BUF-1:0]            done_o
);
  strm_state_e      state_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q, len_q, last_q;
  logic             pick_vld;
  logic [SEL_W-1:0] pick_idx;
  logic [CNT_W-1:0] pick_len;

  function automatic logic [CNT_W-1:0] clamp_len(input logic [REG_W-1:0] raw);
    if (raw > REG_W'(MAX_FRAME)) return CNT_W'(MAX_FRAME);
    return raw[CNT_W-1:0];
  endfunction

  // lowest index wins
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (tx_pend_i[i]) begin
        pick_vld = 1'b1;
        pick_idx = SEL_W'(i);
      end
    end
    pick_len = clamp_len(len_i[pick_idx]);
  end

  assign tx_valid_o = (state_q == ST_SEND);
  assign tx_last_o  = tx_valid_o && (cnt_q == last_q);
  assign tx_len_o   = len_q;
  assign rd_sel_o   = sel_q;
  assign rd_idx_o   = cnt_q[CNT_W-1:2];
  assign tx_data_o  = rd_word_i[{cnt_q[1:0], 3'b000} +: 8];

  always_comb begin
    done_o = '0;
    if (state_q == ST_IDLE) begin
      if (pick_vld && pick_len == '0) done_o[pick_idx] = 1'b1;
    end else if (tx_ready_i && tx_last_o) begin
      done_o[sel_q] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      last_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pick_vld) begin
            sel_q  <= pick_idx;
            cnt_q  <= '0;
            len_q  <= pick_len;
            last_q <= pick_len - CNT_W'(1);
            if (pick_len != '0) state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tx_ready_i) begin
            if (tx_last_o) state_q <= ST_IDLE;
            else           cnt_q   <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mactx_top.sv
module mactx_top
  import mactx_pkg::*;
#(
  parameter int BUF_BYTES = 2048
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            bus_req_i,
  input  logic                            bus_we_i,
  input  logic [$clog2(BUF_BYTES/4)+1:0]  bus_addr_i,
  input  logic [REG_W-1:0]                bus_wdata_i,
  output logic [REG_W-1:0]                bus_rdata_o,
  output logic                            tx_valid_o,
  input  logic                            tx_ready_i,
  output logic [7:0]                      tx_data_o,
  output logic                            tx_last_o,
  output logic [$clog2(BUF_BYTES)-1:0]    tx_len_o,
  output logic [47:0]                     mac_addr_o,
  output logic                            irq_o
);
  localparam int WORDS     = BUF_BYTES / 4;
  localparam int IDX_W     = $clog2(WORDS);
  localparam int LEN_WORD  = WORDS - 3;
  localparam int GIE_WORD  = WORDS - 2;
  localparam int CTRL_WORD = WORDS - 1;

  logic [IDX_W-1:0] a_idx;
  logic [SEL_W-1:0] a_buf;
  logic             a_hi, is_len, is_ctrl, is_gie, wr;

  assign a_idx   = bus_addr_i[IDX_W-1:0];
  assign a_buf   = bus_addr_i[IDX_W +: SEL_W];
  assign a_hi    = bus_addr_i[IDX_W+1];
  assign is_len  = (a_idx == IDX_W'(LEN_WORD));
  assign is_ctrl = (a_idx == IDX_W'(CTRL_WORD));
  assign is_gie  = (a_idx == IDX_W'(GIE_WORD)) && (a_buf == '0);
  assign wr      = bus_req_i && bus_we_i && !a_hi;

  logic [REG_W-1:0]                gie_q;
  logic [NUM_BUF-1:0][REG_W-1:0]   len_q;
  logic [REG_W-1:0]                ctrl_rd  [NUM_BUF];
  logic [31:0]                     ram_rd   [NUM_BUF];
  logic [31:0]                     strm_rd  [NUM_BUF];
  logic [47:0]                     head     [NUM_BUF];
  logic [NUM_BUF-1:0]              tx_pend, addr_load, cmd_done, irq_req, tx_done, busy_s;
  logic [SEL_W-1:0]                rd_sel;
  logic [IDX_W-1:0]                rd_idx;
  logic                            irq_req_any, load_any, gie_en;
  logic [47:0]                     head_sel;
  logic [47:0]                     mac_q;
  logic                            irq_q;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic sel_me;
    assign sel_me = (a_buf == SEL_W'(b));

    mactx_buf_ram #(.WORDS(WORDS)) u_ram (
      .clk_i        (clk_i),
      .we_i         (wr && sel_me && !is_len && !is_ctrl && !is_gie),
      .waddr_i      (a_idx),
      .wdata_i      (bus_wdata_i),
      .bus_raddr_i  (a_idx),
      .bus_rdata_o  (ram_rd[b]),
      .strm_raddr_i (rd_idx),
      .strm_rdata_o (strm_rd[b]),
      .head_o       (head[b])
    );

    mactx_cmd u_cmd (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ctrl_we_i    (wr && sel_me && is_ctrl),
      .ctrl_wdata_i (bus_wdata_i),
      .tx_done_i    (tx_done[b]),
      .ctrl_o       (ctrl_rd[b]),
      .tx_pend_o    (tx_pend[b]),
      .addr_load_o  (addr_load[b]),
      .done_o       (cmd_done[b]),
      .irq_req_o    (irq_req[b])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   len_q[b] <= '0;
      else if (wr && sel_me && is_len) len_q[b] <= bus_wdata_i;
    end

    assign busy_s[b] = ctrl_rd[b][CTRL_S_BIT];
  end

  mactx_stream #(.BUF_BYTES(BUF_BYTES)) u_stream (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_pend_i  (tx_pend),
    .len_i      (len_q),
    .rd_sel_o   (rd_sel),
    .rd_idx_o   (rd_idx),
    .rd_word_i  (strm_rd[rd_sel]),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_data_o  (tx_data_o),
    .tx_last_o  (tx_last_o),
    .tx_len_o   (tx_len_o),
    .done_o     (tx_done)
  );

  always_comb begin
    head_sel = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (addr_load[i]) head_sel = head[i];
    end
  end

  assign irq_req_any = |irq_req;
  assign load_any    = |addr_load;
  assign gie_en      = gie_q[GIE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= '0;
      mac_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr && is_gie) gie_q <= bus_wdata_i;
      if (load_any)     mac_q <= head_sel;
      irq_q <= gie_en & irq_req_any;
    end
  end

  assign mac_addr_o = mac_q;
  assign irq_o      = irq_q;

  always_comb begin
    bus_rdata_o = '0;
    if (!a_hi) begin
      if (is_gie)       bus_rdata_o = gie_q;
      else if (is_len)  bus_rdata_o = len_q[a_buf];
      else if (is_ctrl) bus_rdata_o = ctrl_rd[a_buf];
      else              bus_rdata_o = ram_rd[a_buf];
    end
  end
endmodule

// File: rtl/mactx_chk.sv
module mactx_chk
  import mactx_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tx_valid_i,
  input logic               tx_ready_i,
  input logic [7:0]         tx_data_i,
  input logic               tx_last_i,
  input logic [47:0]        mac_addr_i,
  input logic               irq_i,
  input logic               gie_en_i,
  input logic               irq_req_any_i,
  input logic               load_any_i,
  input logic [NUM_BUF-1:0] cmd_done_i,
  input logic [NUM_BUF-1:0] busy_s_i
);
  // R11
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && !tx_ready_i |=> tx_valid_i && $stable(tx_data_i) && $stable(tx_last_i));

  // R3
  last_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_i |-> tx_valid_i);

  // R8
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(gie_en_i) && $past(irq_req_any_i));

  // R5
  mac_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mac_addr_i) |-> $past(load_any_i));

  // R4
  done_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_done_i) |=> ((busy_s_i & $past(cmd_done_i)) == '0));
endmodule

bind mactx_top mactx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_valid_i    (tx_valid_o),
  .tx_ready_i    (tx_ready_i),
  .tx_data_i     (tx_data_o),
  .tx_last_i     (tx_last_o),
  .mac_addr_i    (mac_addr_o),
  .irq_i         (irq_o),
  .gie_en_i      (gie_en),
  .irq_req_any_i (irq_req_any),
  .load_any_i    (load_any),
  .cmd_done_i    (cmd_done),
  .busy_s_i      (busy_s)
);

// File: tb/mactx_top_test.sv
`timescale 1ns/1ps
module mactx_top_test;
  localparam int A_CTRL0 = 511, A_LEN0 = 509, A_GIE = 510;
  localparam int A_CTRL1 = 1023, A_LEN1 = 1021, B1 = 512;

  // {byte offset, write data, expected read}
  localparam logic [76:0] VEC [12] = '{
    {13'h0000, 32'h1122_3344, 32'h1122_3344},  // R2 buffer 0 data
    {13'h07F0, 32'hA5A5_0001, 32'hA5A5_0001},  // R2
    {13'h0800, 32'hCAFE_F00D, 32'hCAFE_F00D},  // R2 buffer 1 data
    {13'h07F4, 32'h0000_0040, 32'h0000_0040},  // R2 count 0
    {13'h0FF4, 32'h0000_1234, 32'h0000_1234},  // R2 count 1
    {13'h07F8, 32'h8000_0001, 32'h8000_0001},  // R2 enable reg
    {13'h0FF8, 32'h5555_AAAA, 32'h5555_AAAA},  // R2 plain storage
    {13'h1000, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 upper half
    {13'h1FFC, 32'h0000_0001, 32'h0000_0000},  // R2 upper half, no alias
    {13'h07FC, 32'h0000_00F0, 32'h0000_00F0},  // R6
    {13'h0FFC, 32'h0000_000A, 32'h0000_0008},  // R6 P without S
    {13'h07FC, 32'h0000_0000, 32'h0000_0000}   // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tx_valid, tx_ready = 1'b0, tx_last, irq;
  logic [7:0]  tx_data;
  logic [10:0] tx_len;
  logic [47:0] mac;

  int n_chk = 0, n_fail = 0;
  int irq_cnt = 0, cap_n = 0, last_cnt = 0, last_at = -1;
  int ready_mode = 0;
  logic [7:0]  cap [4096];
  logic [10:0] cap_len = '0;
  logic        stall_prev = 1'b0, prev_last = 1'b0;
  logic [7:0]  prev_data = '0;
  logic [31:0] rd;

  mactx_top uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_len_o(tx_len), .mac_addr_o(mac), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  function automatic void check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  function automatic logic [7:0] pat(int b, int k);
    return 8'(k * 5 + b * 97 + 1);
  endfunction

  always @(negedge clk) if (ready_mode == 1) tx_ready <= ~tx_ready;

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (stall_prev)  // R11
        check(tx_valid && tx_data == prev_data && tx_last == prev_last, "R11 stall hold",
              {tx_valid, tx_last, tx_data}, {1'b1, prev_last, prev_data});
      stall_prev = tx_valid && !tx_ready;
      prev_data  = tx_data;
      prev_last  = tx_last;
      if (tx_valid && tx_ready) begin
        if (cap_n < 4096) cap[cap_n] = tx_data;
        if (tx_last) begin last_at = cap_n; last_cnt++; end
        cap_len = tx_len;
        cap_n++;
      end
    end
  end

  task automatic bus_write(int a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 11'(a); bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 11'(a);
    #1 d = bus_rdata;
  endtask

  task automatic fill(int b, int n);
    for (int w = 0; w < (n + 3) / 4; w++)
      bus_write(b * B1 + w, {pat(b, 4*w+3), pat(b, 4*w+2), pat(b, 4*w+1), pat(b, 4*w)});
  endtask

  task automatic clear_cap();
    cap_n = 0; last_cnt = 0; last_at = -1; irq_cnt = 0;
  endtask

  task automatic wait_last(int target);
    for (int t = 0; t < 6000 && last_cnt < target; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_bytes(int b, int base, int n, string tag);
    int bad = 0;
    for (int k = 0; k < n; k++) if (cap[base + k] !== pat(b, k)) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    bus_addr = 11'(A_CTRL0);
    #1;
    check(bus_rdata == 0 && mac == 0 && !irq && !tx_valid, "R1 in reset",
          {bus_rdata, 16'(mac), irq, tx_valid}, 0);
    rst_n = 1'b1;
    bus_read(A_CTRL0, rd); check(rd == 0, "R1 ctrl0", rd, 0);
    bus_read(A_CTRL1, rd); check(rd == 0, "R1 ctrl1", rd, 0);
    bus_read(A_GIE, rd);   check(rd == 0, "R1 enable", rd, 0);
    bus_read(A_LEN0, rd);  check(rd == 0, "R1 count0", rd, 0);

    // R2 / R6 table
    for (int i = 0; i < 12; i++) begin
      bus_write(int'(VEC[i][76:64]) >> 2, VEC[i][63:32]);
      bus_read(int'(VEC[i][76:64]) >> 2, rd);
      check(rd == VEC[i][31:0], $sformatf("R2/R6 vector %0d", i), rd, VEC[i][31:0]);
      check(!tx_valid && mac == 0, $sformatf("R6 no op vector %0d", i), {tx_valid, mac}, 0);
    end

    // R3 R4 R8: plain send with interrupt
    bus_write(A_GIE, 32'h8000_0000);
    fill(0, 5);
    bus_write(A_LEN0, 5);
    tx_ready = 1'b1;
    clear_cap();
    bus_write(A_CTRL0, 32'h9);
    bus_read(A_CTRL0, rd); check(rd == 32'h9, "R4 busy readback", rd, 32'h9);
    wait_last(1);
    bus_read(A_CTRL0, rd); check(rd == 32'h8, "R4 idle readback", rd, 32'h8);
    check(cap_n == 5 && last_at == 4, "R3 count and last", {32'(cap_n), 32'(last_at)}, {32'd5, 32'd4});
    check(cap_len == 5, "R3 length out", cap_len, 5);
    check_bytes(0, 0, 5, "R3 byte order");
    check(irq_cnt == 1, "R8 one pulse", irq_cnt, 1);

    // R5: address load
    bus_write(B1, 32'h4433_2211);
    bus_write(B1 + 1, 32'h0000_6655);
    clear_cap();
    bus_write(A_CTRL1, 32'h3);
    bus_read(A_CTRL1, rd); check(rd == 0, "R5 ctrl clears", rd, 0);
    check(mac == 48'h1122_3344_5566, "R5 station address", mac, 48'h1122_3344_5566);
    repeat (3) @(negedge clk);
    check(cap_n == 0 && irq_cnt == 0, "R5 no stream no irq", {32'(cap_n), 32'(irq_cnt)}, 0);

    // R7 R11: busy buffer ignores writes, throttled sink
    tx_ready = 1'b0;
    fill(0, 2);
    bus_write(A_LEN0, 2);
    clear_cap();
    bus_write(A_CTRL0, 32'h1);
    bus_write(A_CTRL0, 32'hB);
    bus_read(A_CTRL0, rd); check(rd == 32'h1, "R7 write ignored", rd, 32'h1);
    check(mac == 48'h1122_3344_5566, "R7 no address load", mac, 48'h1122_3344_5566);
    ready_mode = 1;
    wait_last(1);
    ready_mode = 0; tx_ready = 1'b1;
    bus_read(A_CTRL0, rd); check(rd == 0, "R7 completes idle", rd, 0);
    check(irq_cnt == 0 && cap_n == 2, "R7 two bytes no irq", {32'(irq_cnt), 32'(cap_n)}, {32'd0, 32'd2});
    check_bytes(0, 0, 2, "R11 bytes under stall");

    // R9: queued send on the other buffer
    tx_ready = 1'b0;
    fill(0, 3); fill(1, 4);
    bus_write(A_LEN0, 3); bus_write(A_LEN1, 4);
    clear_cap();
    bus_write(A_CTRL0, 32'h1);
    bus_write(A_CTRL1, 32'h1);
    bus_read(A_CTRL1, rd); check(rd == 32'h1, "R9 queued busy", rd, 32'h1);
    tx_ready = 1'b1;
    wait_last(2);
    check(cap_n == 7 && last_at == 6, "R9 both frames", {32'(cap_n), 32'(last_at)}, {32'd7, 32'd6});
    check_bytes(0, 0, 3, "R9 first frame");
    check_bytes(1, 3, 4, "R9 second frame");

    // R10: zero length and clamp
    bus_write(A_LEN0, 0);
    clear_cap();
    bus_write(A_CTRL0, 32'h9);
    repeat (3) @(negedge clk);
    bus_read(A_CTRL0, rd); check(rd == 32'h8, "R10 zero length completes", rd, 32'h8);
    check(cap_n == 0 && irq_cnt == 1, "R10 zero length no bytes", {32'(cap_n), 32'(irq_cnt)}, {32'd0, 32'd1});
    fill(1, 2036);
    bus_write(A_LEN1, 32'h0000_FFFF);
    clear_cap();
    bus_write(A_CTRL1, 32'h1);
    wait_last(1);
    check(cap_n == 2036 && last_at == 2035, "R10 clamp count", {32'(cap_n), 32'(last_at)}, {32'd2036, 32'd2035});
    check(cap_len == 11'd2036, "R10 clamp length out", cap_len, 2036);
    check_bytes(1, 0, 2036, "R10 clamp bytes");

    // R8: two completions in one cycle merge
    tx_ready = 1'b0;
    fill(0, 1);
    bus_write(A_LEN0, 1);
    bus_write(B1, 32'hDDCC_BBAA);
    bus_write(B1 + 1, 32'h0000_FFEE);
    clear_cap();
    bus_write(A_CTRL0, 32'h9);
    repeat (2) @(negedge clk);
    bus_write(A_CTRL1, 32'hB);
    tx_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(irq_cnt == 1, "R8 merged pulse", irq_cnt, 1);
    check(mac == 48'hAABB_CCDD_EEFF, "R8 merged address", mac, 48'hAABB_CCDD_EEFF);
    bus_read(A_CTRL0, rd); check(rd == 32'h8, "R8 ctrl0 idle", rd, 32'h8);
    bus_read(A_CTRL1, rd); check(rd == 32'h8, "R8 ctrl1 idle", rd, 32'h8);

    // R8: global enable off
    bus_write(A_GIE, 0);
    bus_write(A_LEN0, 0);
    clear_cap();
    bus_write(A_CTRL0, 32'h9);
    repeat (4) @(negedge clk);
    check(irq_cnt == 0, "R8 gated by enable", irq_cnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule